// File: doc/BRIEF.md
# Instruction Fetch Memory Protection Unit

This unit sits between a processor's instruction-fetch port and its bus interface. Every fetch address is compared in the same cycle against four programmable regions. Each region is a power-of-two sized window, at least 4 KB and aligned to its size, with its own attribute set: a 2-bit access level, a guarded flag and a flag that allows compressed code. The lowest-numbered enabled region that contains the address supplies the attributes. An address that falls in no region uses the attributes of a global region.

A fetch that is allowed goes to the bus unchanged. A fetch that breaks a rule has its bus request cancelled in the same cycle, and an exception goes to the processor with vector offset 0x1300 and a one-hot status word. There is one exception to the cancel: a violating fetch marked as a show cycle still reaches the bus, so that program flow can be traced, and the exception is raised all the same.

The region, global and configuration registers sit behind a simple write/read port and are initialised only by the hard reset. A soft reset leaves every register as it is and puts the unit in a disabled state, in which every fetch is allowed. Protection returns when software writes the configuration enable again.

Top module: `impu_top`

## Requirements
- R1: Hard reset clears every region register (enable off), sets the global attributes to 0xA (access level 2'b10, not guarded, compression allowed) and clears the configuration enable. The unit then forwards every fetch with no exception.
- R2: Register map at reg_addr: 2k is the location of region k (bits [31:12] base, bits [4:0] log2 of the size in bytes). 2k+1 is the attributes of region k (bit 4 enable, bit 3 compression allowed, bit 2 guarded, bits [1:0] access level). 8 is the global attributes (bits [3:0], same layout). 9 is the configuration, with bit 0 as enable. A write takes effect on the next clock edge. reg_rdata shows the addressed register at once, with unused bits reading zero.
- R3: A region covers the 2^size bytes whose upper address bits equal those of its base. A size field below 12 is treated as 12 (4 KB).
- R4: When enabled regions overlap, the lowest-numbered region that matches supplies the attributes.
- R5: A fetch that matches no enabled region is checked against the global attributes.
- R6: Access level 2'b00 denies every fetch. 2'b01 denies user fetches (fetch_user=1) only. 2'b10 and 2'b11 allow both user and supervisor fetches. A denial sets exc_status bit 4.
- R7: A fetch with fetch_comp=1 into a region without compression allowed sets exc_status bit 4.
- R8: A fetch into a guarded region sets exc_status bit 3. If that fetch also breaks an R6 or R7 rule, only bit 4 is set. exc_status is zero when there is no exception and has exactly one bit set when there is one.
- R9: bus_valid follows fetch_valid and bus_addr follows fetch_addr in the same cycle. An allowed fetch raises neither bus_cancel nor exc_req.
- R10: A violating fetch raises exc_req and bus_cancel in the same cycle as fetch_valid. exc_vector is 0x1300. Without fetch_valid, there is no exception and no cancel.
- R11: A violating fetch with fetch_show=1 raises exc_req but not bus_cancel.
- R12: A soft reset leaves every register's readback unchanged and disables checking. Writing the configuration with bit 0 set enables checking again.
- R13: While the configuration enable is clear, no fetch raises an exception or a cancel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, asynchronous, active low |
| srst | input | 1 | Soft reset, synchronous, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_addr | input | 32 | Fetch address |
| fetch_user | input | 1 | 1 = user mode, 0 = supervisor |
| fetch_comp | input | 1 | Fetch is for compressed code |
| fetch_show | input | 1 | Fetch is a show cycle |
| bus_valid | output | 1 | Request to bus interface |
| bus_addr | output | 32 | Address to bus interface |
| bus_cancel | output | 1 | Cancels the current bus request |
| exc_req | output | 1 | Protection exception request |
| exc_vector | output | 16 | Exception vector offset |
| exc_status | output | 32 | One-hot violation status |

## Verification
The assertions assume that fetch inputs are stable between clock edges and that the soft reset and a register write do not touch a region register in the same cycle they check. The soft-reset retention check applies only to cycles without a write. The stimulus changes inputs only on the falling edge. It holds reg_wr low and idles the fetch port while a soft or hard reset pulse is applied. It programs regions only with sizes and bases that respect the alignment rule, except where the 4 KB clamp is exercised on purpose.

// File: rtl/impu_pkg.sv
package impu_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int MIN_SHIFT = 12;
    localparam int BASE_W    = ADDR_W - MIN_SHIFT;
    localparam int SIZE_W    = 5;
    localparam int ST_GUARD  = 3;
    localparam int ST_PROT   = 4;
    localparam logic [15:0] EXC_VEC = 16'h1300;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
    } rgn_loc_t;

    typedef struct packed {
        logic       comp_ok;
        logic       guarded;
        logic [1:0] prot;
    } prot_attr_t;

    typedef struct packed {
        logic       en;
        prot_attr_t pa;
    } rgn_attr_t;

    localparam prot_attr_t GLOB_RST = '{comp_ok: 1'b1, guarded: 1'b0, prot: 2'b10};
endpackage

// File: rtl/impu_regfile.sv
module impu_regfile
    import impu_pkg::*;
#(
    parameter int NUM_RGN = 4,
    parameter int RA_W    = $clog2(2 * NUM_RGN + 2)
) (
    input  logic                      clk,
    input  logic                      hrst_n,
    input  logic                      srst,
    input  logic                      reg_wr,
    input  logic [RA_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output rgn_loc_t  [NUM_RGN-1:0]   loc,
    output rgn_attr_t [NUM_RGN-1:0]   attr,
    output prot_attr_t                glob,
    output logic                      active
);
    localparam int GLOB_IDX = 2 * NUM_RGN;
    localparam int CFG_IDX  = 2 * NUM_RGN + 1;

    typedef struct packed {
        rgn_loc_t  [NUM_RGN-1:0] loc;
        rgn_attr_t [NUM_RGN-1:0] attr;
        prot_attr_t              glob;
        logic                    cfg_en;
        logic                    active;
    } state_t;

    state_t st_d, st_q;

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[MIN_SHIFT-1:SIZE_W]};

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            for (int i = 0; i < NUM_RGN; i++) begin
                if (reg_addr == RA_W'(2 * i)) begin
                    st_d.loc[i].base = reg_wdata[DATA_W-1:MIN_SHIFT];
                    st_d.loc[i].size = reg_wdata[SIZE_W-1:0];
                end
                if (reg_addr == RA_W'(2 * i + 1)) begin
                    st_d.attr[i] = reg_wdata[4:0];
                end
            end
            if (reg_addr == RA_W'(GLOB_IDX)) begin
                st_d.glob = reg_wdata[3:0];
            end
            if (reg_addr == RA_W'(CFG_IDX)) begin
                st_d.cfg_en = reg_wdata[0];
                st_d.active = reg_wdata[0];
            end
        end
        if (srst) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            st_q.loc    <= '0;
            st_q.attr   <= '0;
            st_q.glob   <= GLOB_RST;
            st_q.cfg_en <= 1'b0;
            st_q.active <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (reg_addr == RA_W'(2 * i)) begin
                reg_rdata = {st_q.loc[i].base, {(MIN_SHIFT - SIZE_W){1'b0}}, st_q.loc[i].size};
            end
            if (reg_addr == RA_W'(2 * i + 1)) begin
                reg_rdata = {{(DATA_W - 5){1'b0}}, st_q.attr[i]};
            end
        end
        if (reg_addr == RA_W'(GLOB_IDX)) begin
            reg_rdata = {{(DATA_W - 4){1'b0}}, st_q.glob};
        end
        if (reg_addr == RA_W'(CFG_IDX)) begin
            reg_rdata = {{(DATA_W - 1){1'b0}}, st_q.cfg_en};
        end
    end

    assign loc    = st_q.loc;
    assign attr   = st_q.attr;
    assign glob   = st_q.glob;
    assign active = st_q.active;

    // R12: a soft reset always leaves the unit disabled afterwards
    p_srst_disables_r12: assert property (@(posedge clk) disable iff (!hrst_n)
        srst |=> !st_q.active);

    // R12: a soft reset without a write keeps every register
    p_srst_keeps_regs_r12: assert property (@(posedge clk) disable iff (!hrst_n)
        (srst && !reg_wr) |=> ($stable(st_q.loc) && $stable(st_q.attr)
                               && $stable(st_q.glob) && $stable(st_q.cfg_en)));

    // R13: checking can only become active through a configuration write
    p_enable_via_write_r13: assert property (@(posedge clk) disable iff (!hrst_n)
        $rose(st_q.active) |-> $past(reg_wr && reg_addr == RA_W'(CFG_IDX) && reg_wdata[0]));
endmodule

// File: rtl/impu_region_match.sv
module impu_region_match
    import impu_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  rgn_loc_t          loc,
    input  logic              en,
    output logic              hit
);
    logic [SIZE_W-1:0] shift;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_addr;

    always_comb begin
        shift     = (loc.size < SIZE_W'(MIN_SHIFT)) ? SIZE_W'(MIN_SHIFT) : loc.size;
        mask      = {ADDR_W{1'b1}} << shift;
        base_addr = {loc.base, {MIN_SHIFT{1'b0}}};
        hit       = en && ((addr & mask) == (base_addr & mask));
    end
endmodule

// File: rtl/impu_attr_check.sv
module impu_attr_check
    import impu_pkg::*;
#(
    parameter int NUM_RGN = 4
) (
    input  logic                     clk,
    input  logic                     hrst_n,
    input  logic [NUM_RGN-1:0]       hits,
    input  rgn_attr_t [NUM_RGN-1:0]  attr,
    input  prot_attr_t               glob,
    input  logic                     active,
    input  logic                     valid,
    input  logic                     user,
    input  logic                     comp,
    output logic                     viol,
    output logic [DATA_W-1:0]        status
);
    prot_attr_t eff;
    logic       prot_bad;
    logic       comp_bad;

    always_comb begin
        eff = glob;
        for (int i = NUM_RGN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                eff = attr[i].pa;
            end
        end
        prot_bad = (eff.prot == 2'b00) || (eff.prot == 2'b01 && user);
        comp_bad = comp && !eff.comp_ok;
        status   = '0;
        if (valid && active) begin
            if (prot_bad || comp_bad) begin
                status[ST_PROT] = 1'b1;
            end else if (eff.guarded) begin
                status[ST_GUARD] = 1'b1;
            end
        end
        viol = |status;
    end

    // R8: exactly one status bit during an exception, none otherwise
    p_status_onehot_r8: assert property (@(posedge clk) disable iff (!hrst_n)
        viol |-> ($countones(status) == 1));
    p_status_idle_r8: assert property (@(posedge clk) disable iff (!hrst_n)
        !viol |-> (status == '0));

    // R13: a disabled unit never flags a violation
    p_quiet_when_off_r13: assert property (@(posedge clk) disable iff (!hrst_n)
        !active |-> !viol);
endmodule

// File: rtl/impu_top.sv
module impu_top
    import impu_pkg::*;
#(
    parameter int NUM_RGN = 4,
    parameter int RA_W    = $clog2(2 * NUM_RGN + 2)
) (
    input  logic              clk,
    input  logic              hrst_n,
    input  logic              srst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_user,
    input  logic              fetch_comp,
    input  logic              fetch_show,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cancel,
    output logic              exc_req,
    output logic [15:0]       exc_vector,
    output logic [DATA_W-1:0] exc_status
);
    rgn_loc_t  [NUM_RGN-1:0] loc;
    rgn_attr_t [NUM_RGN-1:0] attr;
    prot_attr_t              glob;
    logic                    active;
    logic [NUM_RGN-1:0]      hits;
    logic                    viol;

    impu_regfile #(.NUM_RGN(NUM_RGN), .RA_W(RA_W)) u_regs (
        .clk      (clk),
        .hrst_n   (hrst_n),
        .srst     (srst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .loc      (loc),
        .attr     (attr),
        .glob     (glob),
        .active   (active)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_match
        impu_region_match u_match (
            .addr(fetch_addr),
            .loc (loc[g]),
            .en  (attr[g].en),
            .hit (hits[g])
        );
    end

    impu_attr_check #(.NUM_RGN(NUM_RGN)) u_check (
        .clk   (clk),
        .hrst_n(hrst_n),
        .hits  (hits),
        .attr  (attr),
        .glob  (glob),
        .active(active),
        .valid (fetch_valid),
        .user  (fetch_user),
        .comp  (fetch_comp),
        .viol  (viol),
        .status(exc_status)
    );

    assign bus_valid  = fetch_valid;
    assign bus_addr   = fetch_addr;
    assign exc_req    = viol;
    assign bus_cancel = viol && !fetch_show;
    assign exc_vector = EXC_VEC;

    // R10: a cancel only accompanies an exception on a valid fetch
    p_cancel_has_exc_r10: assert property (@(posedge clk) disable iff (!hrst_n)
        bus_cancel |-> (exc_req && fetch_valid));

    // R10: no exception without a fetch
    p_no_exc_idle_r10: assert property (@(posedge clk) disable iff (!hrst_n)
        !fetch_valid |-> (!exc_req && !bus_cancel));

    // R11: show cycles are never cancelled
    p_show_not_cancelled_r11: assert property (@(posedge clk) disable iff (!hrst_n)
        (fetch_valid && fetch_show) |-> !bus_cancel);
endmodule

// File: tb/tb_impu_top.sv
module tb_impu_top;
    logic        clk = 1'b0;
    logic        hrst_n = 1'b0;
    logic        srst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_user = 1'b0;
    logic        fetch_comp = 1'b0;
    logic        fetch_show = 1'b0;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic        bus_cancel;
    logic        exc_req;
    logic [15:0] exc_vector;
    logic [31:0] exc_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic        bv;
        logic [31:0] ba;
        logic        cancel;
        logic        exc;
        logic [31:0] status;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    impu_top dut (
        .clk(clk), .hrst_n(hrst_n), .srst(srst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_user(fetch_user),
        .fetch_comp(fetch_comp), .fetch_show(fetch_show),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_cancel(bus_cancel),
        .exc_req(exc_req), .exc_vector(exc_vector), .exc_status(exc_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per cycle, sampled 2 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " bus_valid"}, 32'(bus_valid), 32'(e.bv));
                chk({e.tag, " bus_addr"}, bus_addr, e.ba);
                chk({e.tag, " bus_cancel"}, 32'(bus_cancel), 32'(e.cancel));
                chk({e.tag, " exc_req"}, 32'(exc_req), 32'(e.exc));
                chk({e.tag, " exc_status"}, exc_status, e.status);
                if (e.exc) chk({e.tag, " exc_vector R10"}, 32'(exc_vector), 32'h1300);
            end
        end
    end

    // driver: one fetch per cycle, expectation pushed in the same cycle
    task automatic fetch(input string tag, input logic [31:0] a, input logic u, input logic c,
                         input logic sh, input logic v, input logic e, input int bitn);
        exp_t x;
        @(negedge clk);
        reg_wr = 1'b0;
        fetch_valid = v; fetch_addr = a; fetch_user = u; fetch_comp = c; fetch_show = sh;
        x.bv = v; x.ba = a; x.exc = e; x.cancel = e && !sh;
        x.status = e ? (32'h1 << bitn) : 32'h0;
        x.tag = tag;
        sb_q.push_back(x);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        fetch_valid = 1'b0;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        fetch_valid = 1'b0; reg_wr = 1'b0; reg_addr = a;
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic program_regions();
        wr(4'd0, 32'h0000_100C); wr(4'd1, 32'h19); // r0 4KB @0x1000, supervisor only
        wr(4'd2, 32'h0001_0010); wr(4'd3, 32'h10); // r1 64KB @0x10000, no access
        wr(4'd4, 32'h0000_0010); wr(4'd5, 32'h1F); // r2 64KB @0, guarded, overlaps r0
        wr(4'd6, 32'h0002_0005); wr(4'd7, 32'h12); // r3 size 5 -> 4KB @0x20000, no compression
        wr(4'd8, 32'h9);                           // global: supervisor only
    endtask

    initial begin
        repeat (3) @(negedge clk);
        hrst_n = 1'b1;

        // R1: reset state
        rd("R1 cfg reset", 4'd9, 32'h0);
        rd("R1 region1 attr reset", 4'd3, 32'h0);
        rd("R1 region0 loc reset", 4'd0, 32'h0);
        rd("R1 global reset", 4'd8, 32'hA);
        fetch("R1 reset forwards", 32'h0000_1010, 1, 1, 0, 1, 0, 0);

        program_regions();
        // R2: readback
        rd("R2 loc readback", 4'd6, 32'h0002_0005);
        rd("R2 attr readback", 4'd5, 32'h1F);
        rd("R2 global readback", 4'd8, 32'h9);

        // R13: not enabled yet
        fetch("R13 disabled no-access region", 32'h0001_8000, 0, 0, 0, 1, 0, 0);
        wr(4'd9, 32'h1);
        rd("R2 cfg readback", 4'd9, 32'h1);

        fetch("R4 R6 user in sup-only r0", 32'h0000_1010, 1, 0, 0, 1, 1, 4);
        fetch("R9 sup in r0 allowed", 32'h0000_1010, 0, 0, 0, 1, 0, 0);
        fetch("R4 R8 guarded r2", 32'h0000_2000, 0, 0, 0, 1, 1, 3);
        fetch("R8 guarded r2 user comp", 32'h0000_2000, 1, 1, 0, 1, 1, 3);
        fetch("R3 R6 no access 64KB r1", 32'h0001_8000, 0, 0, 0, 1, 1, 4);
        fetch("R3 r3 top of 4KB ok", 32'h0002_0FFC, 0, 0, 0, 1, 0, 0);
        fetch("R7 compressed into r3", 32'h0002_0FFC, 1, 1, 0, 1, 1, 4);
        fetch("R3 R5 past clamp user global", 32'h0002_1000, 1, 0, 0, 1, 1, 4);
        fetch("R5 global sup ok", 32'h0002_1000, 0, 0, 0, 1, 0, 0);
        fetch("R5 R7 global allows comp", 32'h0005_0000, 0, 1, 0, 1, 0, 0);
        fetch("R11 show cycle violation", 32'h0001_8000, 0, 0, 1, 1, 1, 4);
        fetch("R10 no valid no exc", 32'h0001_8000, 0, 0, 0, 0, 0, 0);
        fetch("R10 back to back violation", 32'h0001_0004, 1, 0, 0, 1, 1, 4);

        // R8: guarded and sup-only together
        wr(4'd5, 32'h1D);
        fetch("R8 guarded plus prot -> bit4 only", 32'h0000_2000, 1, 0, 0, 1, 1, 4);
        fetch("R8 guarded sup -> bit3", 32'h0000_2000, 0, 0, 0, 1, 1, 3);
        wr(4'd3, 32'h12);
        fetch("R6 level 2'b10 user ok", 32'h0001_8000, 1, 0, 0, 1, 0, 0);
        wr(4'd3, 32'h13);
        fetch("R6 level 2'b11 user ok", 32'h0001_8000, 1, 0, 0, 1, 0, 0);
        wr(4'd3, 32'h10);

        // R12: soft reset
        @(negedge clk); fetch_valid = 1'b0; srst = 1'b1;
        @(negedge clk); srst = 1'b0;
        rd("R12 loc kept", 4'd2, 32'h0001_0010);
        rd("R12 attr kept", 4'd5, 32'h1D);
        rd("R12 global kept", 4'd8, 32'h9);
        rd("R12 cfg kept", 4'd9, 32'h1);
        fetch("R12 disabled after soft reset", 32'h0001_8000, 0, 0, 0, 1, 0, 0);
        wr(4'd9, 32'h1);
        fetch("R12 re-enabled", 32'h0001_8000, 0, 0, 0, 1, 1, 4);

        // R13: enable cleared by write
        wr(4'd9, 32'h0);
        fetch("R13 cfg off", 32'h0001_8000, 1, 1, 0, 1, 0, 0);

        // R1: hard reset mid-run
        @(negedge clk); fetch_valid = 1'b0; hrst_n = 1'b0;
        @(negedge clk); hrst_n = 1'b1;
        rd("R1 loc after hard reset", 4'd2, 32'h0);
        rd("R1 global after hard reset", 4'd8, 32'hA);

        @(negedge clk); fetch_valid = 1'b0;
        @(negedge clk);
        #3;
        if (sb_q.size() != 0) chk("scoreboard drained", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule